// File: doc/BRIEF.md
# Legacy and Low-Memory Address Router

This block sorts each memory request that falls below the top of low usable memory. It sends the request either to DRAM or to a downstream I/O link. A request carries an address, a read/write flag, a requester class and byte enables. The block returns a destination, a snoop-required flag, an address and byte enables that may have been rewritten, and an error flag. All outputs come from one register stage, so the response follows the request by exactly one clock.

Two address areas are decoded.

The legacy window spans 768 KB to 1 MB. It is cut into thirteen segments. Each segment has its own read-enable bit and write-enable bit, and the outcome depends on those bits together with the requester class.

The main range starts at 1 MB and ends just below a programmable top-of-low-usable-memory boundary. It normally goes to DRAM. Three exception regions can be enabled within it, and each of them diverts its hits to the I/O link:
- a fixed 15 MB–16 MB hole;
- a base/size system-management segment;
- a base/size graphics stolen-memory region.

Top module: `lowmem_router`

## Requirements
- R1: While reset is asserted, every output is zero. After reset, `rsp_valid` equals `req_valid` from one clock earlier. A cycle with `req_valid` low gives all outputs zero one clock later.
- R2: The legacy window is split into thirteen segments. Segment i, for i = 0 to 11, covers 0xC0000 + i·0x4000 through that address + 0x3FFF. Segment 12 covers 0xF0000–0xFFFFF. Segment i uses bit i of `cfg_rd_en` and bit i of `cfg_wr_en`.
- R3: A core request (`req_class` = 0) that hits the window goes to DRAM (`rsp_dest` = 0) when the enable bit for its direction is set, and otherwise goes to the I/O link (`rsp_dest` = 1). Reads use the read enable and writes use the write enable.
- R4: A snooped I/O request (`req_class` = 1) that hits the window is routed as in R3 and raises `rsp_snoop`. `rsp_snoop` is zero in every other case.
- R5: A non-snooped I/O request (`req_class` = 2) that hits the window goes to DRAM, whatever the enable bits hold.
- R6: A graphics-translated request (`req_class` = 3) that hits the window raises `rsp_err`, gets `rsp_addr` = 0xC0000 and goes to DRAM. For a write, `rsp_be` is all zero; for a read, the byte enables are passed through. `rsp_err` is zero in every other case.
- R7: Outside the window, address and byte enables pass through unchanged. Addresses below 0xC0000 go to DRAM. An address from 0x100000 up to `cfg_tolud` − 1 goes to DRAM unless R8–R10 apply. An address at or above `cfg_tolud` (and at least 0x100000) goes to the I/O link.
- R8: When `cfg_hole_en` is set, addresses 0xF00000–0xFFFFFF go to the I/O link.
- R9: When `cfg_smm_en` is set, addresses from `cfg_smm_base` up to `cfg_smm_base + cfg_smm_size` − 1 that lie at or above 1 MB go to the I/O link.
- R10: When `cfg_gfx_en` is set, addresses from `cfg_gfx_base` up to `cfg_gfx_base + cfg_gfx_size` − 1 that lie at or above 1 MB go to the I/O link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_class | input | 2 | 0 core, 1 snooped I/O, 2 non-snooped I/O, 3 graphics-translated |
| req_be | input | BE_W | Request byte enables |
| cfg_rd_en | input | N_SEG | Read enable for each legacy segment |
| cfg_wr_en | input | N_SEG | Write enable for each legacy segment |
| cfg_tolud | input | ADDR_W | Exclusive top of low usable memory |
| cfg_hole_en | input | 1 | Enable the 15 MB–16 MB hole |
| cfg_smm_en | input | 1 | Enable the system-management segment |
| cfg_smm_base | input | ADDR_W | Base of the system-management segment |
| cfg_smm_size | input | ADDR_W | Size of the system-management segment in bytes |
| cfg_gfx_en | input | 1 | Enable the graphics stolen region |
| cfg_gfx_base | input | ADDR_W | Base of the graphics stolen region |
| cfg_gfx_size | input | ADDR_W | Size of the graphics stolen region in bytes |
| rsp_valid | output | 1 | Registered request valid |
| rsp_dest | output | 1 | 0 DRAM, 1 I/O link |
| rsp_snoop | output | 1 | Snoop required |
| rsp_err | output | 1 | Mapping error |
| rsp_addr | output | ADDR_W | Address, possibly rewritten |
| rsp_be | output | BE_W | Byte enables, possibly cleared |

## Verification
The bench builds the router with its default parameters:
- a 32-bit address and 4-bit byte enables;
- twelve 16 KB segments plus one 64 KB segment;
- both optional exception regions generated.

With these values, every one of the thirteen segment edges can be reached, and each edge is tried under each pairing of read and write enable, each requester class and both directions. In that sweep the enable bits of all other segments are set to the opposite value, so picking the wrong segment shows up. Because both region variants are present, the system-management and stolen-memory paths can be hit at their edges, next to the fixed hole and the movable top boundary.

// File: rtl/lowmem_pkg.sv
package lowmem_pkg;

   typedef enum logic [1:0] {
      CLS_CORE    = 2'd0,
      CLS_SNP_IO  = 2'd1,
      CLS_NSNP_IO = 2'd2,
      CLS_GFX_XL  = 2'd3
   } req_cls_e;

   typedef enum logic {
      DST_DRAM = 1'b0,
      DST_LINK = 1'b1
   } dest_e;

   typedef struct packed {
      logic dest;
      logic snoop;
      logic err;
   } route_flags_t;

   // Start of the legacy window (768 KB).
   localparam longint unsigned LEGACY_BASE = 64'h0000_0000_000C_0000;

endpackage

// File: rtl/legacy_window_dec.sv
module legacy_window_dec #(
   parameter int ADDR_W = 32,
   parameter longint unsigned WIN_BASE = 64'h000C_0000,
   parameter int SMALL_LOG2 = 14,
   parameter int N_SMALL = 12,
   parameter int BIG_LOG2 = 16,
   localparam int N_SEG = N_SMALL + 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_SEG-1:0]  seg_hit,
   output logic              in_win
);

   localparam longint unsigned SMALL_SZ = 64'd1 << SMALL_LOG2;
   localparam longint unsigned BIG_SZ   = 64'd1 << BIG_LOG2;

   logic [63:0] addr_x;
   assign addr_x = 64'(addr);

   // One comparator pair per segment; the last segment is the large one.
   for (genvar g = 0; g < N_SEG; g++) begin : g_seg
      localparam longint unsigned LO = WIN_BASE + SMALL_SZ * 64'(g);
      localparam longint unsigned HI = LO + ((g < N_SMALL) ? SMALL_SZ : BIG_SZ);
      assign seg_hit[g] = (addr_x >= LO) && (addr_x < HI);
   end

   assign in_win = |seg_hit;

endmodule

// File: rtl/region_hit.sv
module region_hit #(
   parameter int ADDR_W = 32
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] size,
   output logic              hit
);

   // The limit is one bit wider, so a region that ends at the top of the
   // address space does not wrap.
   logic [ADDR_W:0] limit;
   assign limit = {1'b0, base} + {1'b0, size};
   assign hit   = en && (addr >= base) && ({1'b0, addr} < limit);

endmodule

// File: rtl/route_core.sv
module route_core
   import lowmem_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BE_W = 4,
   parameter longint unsigned WIN_BASE = 64'h000C_0000,
   parameter longint unsigned MAIN_LO = 64'h0010_0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              write,
   input  req_cls_e          cls,
   input  logic [BE_W-1:0]   be,
   input  logic              in_win,
   input  logic              attr_rd,
   input  logic              attr_wr,
   input  logic [ADDR_W-1:0] tolud,
   input  logic              excp_hit,
   output route_flags_t      flags,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BE_W-1:0]   be_o
);

   logic attr_ok;
   logic in_main;
   logic below_top;

   assign attr_ok   = write ? attr_wr : attr_rd;
   assign in_main   = 64'(addr) >= MAIN_LO;
   assign below_top = addr < tolud;

   always_comb begin
      flags  = '0;
      addr_o = addr;
      be_o   = be;
      if (in_win) begin
         case (cls)
            CLS_CORE: begin
               flags.dest = attr_ok ? DST_DRAM : DST_LINK;
            end
            CLS_SNP_IO: begin
               flags.dest  = attr_ok ? DST_DRAM : DST_LINK;
               flags.snoop = 1'b1;
            end
            CLS_NSNP_IO: begin
               flags.dest = DST_DRAM;
            end
            CLS_GFX_XL: begin
               flags.dest = DST_DRAM;
               flags.err  = 1'b1;
               addr_o     = ADDR_W'(WIN_BASE);
               if (write) begin
                  be_o = '0;
               end
            end
            default: begin
               flags.dest = DST_LINK;
            end
         endcase
      end else if (in_main) begin
         flags.dest = (below_top && !excp_hit) ? DST_DRAM : DST_LINK;
      end
   end

endmodule

// File: rtl/lowmem_router.sv
module lowmem_router
   import lowmem_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BE_W = 4,
   parameter int SMALL_LOG2 = 14,
   parameter int N_SMALL = 12,
   parameter int BIG_LOG2 = 16,
   parameter bit HAS_SMM = 1'b1,
   parameter bit HAS_GFX = 1'b1,
   parameter longint unsigned HOLE_BASE = 64'h00F0_0000,
   parameter int HOLE_LOG2 = 20,
   localparam int N_SEG = N_SMALL + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [1:0]        req_class,
   input  logic [BE_W-1:0]   req_be,
   input  logic [N_SEG-1:0]  cfg_rd_en,
   input  logic [N_SEG-1:0]  cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_tolud,
   input  logic              cfg_hole_en,
   input  logic              cfg_smm_en,
   input  logic [ADDR_W-1:0] cfg_smm_base,
   input  logic [ADDR_W-1:0] cfg_smm_size,
   input  logic              cfg_gfx_en,
   input  logic [ADDR_W-1:0] cfg_gfx_base,
   input  logic [ADDR_W-1:0] cfg_gfx_size,
   output logic              rsp_valid,
   output logic              rsp_dest,
   output logic              rsp_snoop,
   output logic              rsp_err,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [BE_W-1:0]   rsp_be
);

   localparam longint unsigned WIN_BASE = LEGACY_BASE;
   localparam longint unsigned WIN_SIZE =
      (64'd1 << SMALL_LOG2) * 64'(N_SMALL) + (64'd1 << BIG_LOG2);
   localparam longint unsigned MAIN_LO  = WIN_BASE + WIN_SIZE;
   localparam longint unsigned HOLE_SZ  = 64'd1 << HOLE_LOG2;

   // Checks on the parameters, made when the design is elaborated.
   if (ADDR_W < 24 || ADDR_W > 63) begin : g_chk_aw
      $error("lowmem_router: ADDR_W must lie in 24..63");
   end
   if (BE_W < 1) begin : g_chk_be
      $error("lowmem_router: BE_W must be at least 1");
   end
   if (HOLE_BASE < MAIN_LO) begin : g_chk_hole
      $error("lowmem_router: hole must lie above the legacy window");
   end
   if (BIG_LOG2 < SMALL_LOG2) begin : g_chk_seg
      $error("lowmem_router: last segment must not be smaller than the others");
   end

   logic [N_SEG-1:0]  seg_hit;
   logic              in_win;
   logic              hole_hit;
   logic              smm_hit;
   logic              gfx_hit;
   logic              excp_hit;
   route_flags_t      flags;
   logic [ADDR_W-1:0] addr_nx;
   logic [BE_W-1:0]   be_nx;

   legacy_window_dec #(
      .ADDR_W(ADDR_W),
      .WIN_BASE(WIN_BASE),
      .SMALL_LOG2(SMALL_LOG2),
      .N_SMALL(N_SMALL),
      .BIG_LOG2(BIG_LOG2)
   ) u_win (
      .addr(req_addr),
      .seg_hit(seg_hit),
      .in_win(in_win)
   );

   region_hit #(.ADDR_W(ADDR_W)) u_hole (
      .en(cfg_hole_en),
      .addr(req_addr),
      .base(ADDR_W'(HOLE_BASE)),
      .size(ADDR_W'(HOLE_SZ)),
      .hit(hole_hit)
   );

   if (HAS_SMM) begin : g_smm
      region_hit #(.ADDR_W(ADDR_W)) u_smm (
         .en(cfg_smm_en),
         .addr(req_addr),
         .base(cfg_smm_base),
         .size(cfg_smm_size),
         .hit(smm_hit)
      );
   end else begin : g_no_smm
      assign smm_hit = 1'b0;
   end

   if (HAS_GFX) begin : g_gfx
      region_hit #(.ADDR_W(ADDR_W)) u_gfx (
         .en(cfg_gfx_en),
         .addr(req_addr),
         .base(cfg_gfx_base),
         .size(cfg_gfx_size),
         .hit(gfx_hit)
      );
   end else begin : g_no_gfx
      assign gfx_hit = 1'b0;
   end

   assign excp_hit = hole_hit || smm_hit || gfx_hit;

   route_core #(
      .ADDR_W(ADDR_W),
      .BE_W(BE_W),
      .WIN_BASE(WIN_BASE),
      .MAIN_LO(MAIN_LO)
   ) u_route (
      .addr(req_addr),
      .write(req_write),
      .cls(req_cls_e'(req_class)),
      .be(req_be),
      .in_win(in_win),
      .attr_rd(|(seg_hit & cfg_rd_en)),
      .attr_wr(|(seg_hit & cfg_wr_en)),
      .tolud(cfg_tolud),
      .excp_hit(excp_hit),
      .flags(flags),
      .addr_o(addr_nx),
      .be_o(be_nx)
   );

   // Output stage; the payload is forced to zero on idle cycles.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_dest  <= 1'b0;
         rsp_snoop <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_addr  <= '0;
         rsp_be    <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_dest  <= flags.dest;
            rsp_snoop <= flags.snoop;
            rsp_err   <= flags.err;
            rsp_addr  <= addr_nx;
            rsp_be    <= be_nx;
         end else begin
            rsp_dest  <= 1'b0;
            rsp_snoop <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_addr  <= '0;
            rsp_be    <= '0;
         end
      end
   end

endmodule

// File: rtl/lowmem_router_chk.sv
module lowmem_router_chk #(
   parameter int ADDR_W = 32,
   parameter int BE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic [1:0]        req_class,
   input logic              cfg_hole_en,
   input logic              rsp_valid,
   input logic              rsp_dest,
   input logic              rsp_snoop,
   input logic              rsp_err,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic [BE_W-1:0]   rsp_be
);

   logic legacy;
   logic in_hole;
   assign legacy  = (64'(req_addr) >= 64'h000C_0000) && (64'(req_addr) < 64'h0010_0000);
   assign in_hole = (64'(req_addr) >= 64'h00F0_0000) && (64'(req_addr) < 64'h0100_0000);

   p_valid_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_idle_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_err && !rsp_snoop));

   p_snoop_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && legacy && req_class == 2'd1) |=> rsp_snoop);

   p_snoop_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_class != 2'd1) |=> !rsp_snoop);

   p_nosnoop_dram_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && legacy && req_class == 2'd2) |=> (rsp_dest == 1'b0));

   p_gfx_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && legacy && req_class == 2'd3) |=> (rsp_err && rsp_addr == ADDR_W'(32'h000C_0000)));

   p_gfx_be_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && legacy && req_class == 2'd3 && req_write) |=> (rsp_be == '0));

   p_err_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !legacy) |=> !rsp_err);

   p_hole_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cfg_hole_en && in_hole) |=> rsp_dest);

endmodule

bind lowmem_router lowmem_router_chk #(
   .ADDR_W(ADDR_W),
   .BE_W(BE_W)
) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .req_valid(req_valid),
   .req_addr(req_addr),
   .req_write(req_write),
   .req_class(req_class),
   .cfg_hole_en(cfg_hole_en),
   .rsp_valid(rsp_valid),
   .rsp_dest(rsp_dest),
   .rsp_snoop(rsp_snoop),
   .rsp_err(rsp_err),
   .rsp_addr(rsp_addr),
   .rsp_be(rsp_be)
);

// File: tb/sim_lowmem_router.sv
module sim_lowmem_router;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int BW = 4;
   localparam int NS = 13;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic [AW-1:0] req_addr;
   logic          req_write;
   logic [1:0]    req_class;
   logic [BW-1:0] req_be;
   logic [NS-1:0] cfg_rd_en, cfg_wr_en;
   logic [AW-1:0] cfg_tolud;
   logic          cfg_hole_en, cfg_smm_en, cfg_gfx_en;
   logic [AW-1:0] cfg_smm_base, cfg_smm_size, cfg_gfx_base, cfg_gfx_size;
   logic          rsp_valid, rsp_dest, rsp_snoop, rsp_err;
   logic [AW-1:0] rsp_addr;
   logic [BW-1:0] rsp_be;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lowmem_router u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_class(req_class), .req_be(req_be),
      .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en), .cfg_tolud(cfg_tolud),
      .cfg_hole_en(cfg_hole_en),
      .cfg_smm_en(cfg_smm_en), .cfg_smm_base(cfg_smm_base), .cfg_smm_size(cfg_smm_size),
      .cfg_gfx_en(cfg_gfx_en), .cfg_gfx_base(cfg_gfx_base), .cfg_gfx_size(cfg_gfx_size),
      .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_snoop(rsp_snoop),
      .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_be(rsp_be)
   );

   // Behavioural reference: computes the expected response from the requirements.
   task automatic model(input logic [31:0] a, input logic w, input logic [1:0] c,
                        input logic [3:0] be, output logic d, output logic s,
                        output logic e, output logic [31:0] oa, output logic [3:0] ob,
                        output string tag);
      longint unsigned ax = 64'(a);
      int seg;
      logic en_bit;
      d = 1'b0; s = 1'b0; e = 1'b0; oa = a; ob = be; tag = "R7";
      if (ax >= 64'hC0000 && ax < 64'h100000) begin
         seg = (ax < 64'hF0000) ? int'((ax - 64'hC0000) / 64'd16384) : 12;
         en_bit = w ? cfg_wr_en[seg] : cfg_rd_en[seg];
         case (c)
            2'd0: begin d = !en_bit; tag = "R2/R3"; end
            2'd1: begin d = !en_bit; s = 1'b1; tag = "R4"; end
            2'd2: begin d = 1'b0; tag = "R5"; end
            default: begin
               d = 1'b0; e = 1'b1; oa = 32'h000C_0000;
               if (w) ob = 4'b0000;
               tag = "R6";
            end
         endcase
      end else if (ax >= 64'h100000) begin
         if (ax >= 64'(cfg_tolud)) begin
            d = 1'b1; tag = "R7";
         end else if (cfg_hole_en && ax >= 64'hF00000 && ax < 64'h1000000) begin
            d = 1'b1; tag = "R8";
         end else if (cfg_smm_en && ax >= 64'(cfg_smm_base)
                      && ax < 64'(cfg_smm_base) + 64'(cfg_smm_size)) begin
            d = 1'b1; tag = "R9";
         end else if (cfg_gfx_en && ax >= 64'(cfg_gfx_base)
                      && ax < 64'(cfg_gfx_base) + 64'(cfg_gfx_size)) begin
            d = 1'b1; tag = "R10";
         end
      end
   endtask

   task automatic compare(input string tag, input logic ev, input logic ed,
                          input logic es, input logic ee, input logic [31:0] ea,
                          input logic [3:0] eb);
      checks++;
      if ({rsp_valid, rsp_dest, rsp_snoop, rsp_err, rsp_addr, rsp_be} !==
          {ev, ed, es, ee, ea, eb}) begin
         errors++;
         $display("FAIL %s: got v=%0b d=%0b s=%0b e=%0b a=%h be=%b, expected v=%0b d=%0b s=%0b e=%0b a=%h be=%b",
                  tag, rsp_valid, rsp_dest, rsp_snoop, rsp_err, rsp_addr, rsp_be,
                  ev, ed, es, ee, ea, eb);
      end
   endtask

   // Drive one cycle at a falling edge and compare at the next falling edge.
   task automatic step(input logic v, input logic [31:0] a, input logic w,
                       input logic [1:0] c, input logic [3:0] be);
      logic d, s, e;
      logic [31:0] oa;
      logic [3:0] ob;
      string tag;
      req_valid = v; req_addr = a; req_write = w; req_class = c; req_be = be;
      if (v) begin
         model(a, w, c, be, d, s, e, oa, ob, tag);
      end else begin
         d = 1'b0; s = 1'b0; e = 1'b0; oa = '0; ob = '0; tag = "R1";
      end
      @(negedge clk);
      compare(tag, v, d, s, e, oa, ob);
   endtask

   logic [31:0] maddr [17] = '{
      32'h000B_FFFF, 32'h0010_0000, 32'h001F_FFFF, 32'h0020_0000, 32'h002F_FFFF,
      32'h0030_0000, 32'h00EF_FFFF, 32'h00F0_0000, 32'h00FF_FFFF, 32'h0100_0000,
      32'h02FF_FFFF, 32'h0300_0000, 32'h037F_FFFF, 32'h0380_0000, 32'h03FF_FFFF,
      32'h0400_0000, 32'hFFFF_FFFF
   };

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL R1 watchdog: got run still active, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_class = 2'd0; req_be = '0;
      cfg_rd_en = '0; cfg_wr_en = '0; cfg_tolud = 32'h0400_0000;
      cfg_hole_en = 1'b0; cfg_smm_en = 1'b0; cfg_gfx_en = 1'b0;
      cfg_smm_base = 32'h0020_0000; cfg_smm_size = 32'h0010_0000;
      cfg_gfx_base = 32'h0300_0000; cfg_gfx_size = 32'h0080_0000;
      req_valid = 1'b1; req_addr = 32'h000C_0000; req_class = 2'd3;
      repeat (3) @(negedge clk);
      compare("R1", 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 4'h0);   // R1 reset state
      rst_n = 1'b1;
      step(1'b0, 32'h000C_0000, 1'b1, 2'd3, 4'hF);           // R1 idle cycle

      // R2..R6: every segment edge, every enable pairing, class and direction.
      for (int seg = 0; seg < NS; seg++) begin
         logic [NS-1:0] bitv = NS'(1) << seg;
         logic [31:0] lo = 32'h000C_0000 + 32'(seg) * 32'h4000;
         logic [31:0] hi = (seg < 12) ? lo + 32'h3FFF : 32'h000F_FFFF;
         for (int combo = 0; combo < 4; combo++) begin
            cfg_rd_en = combo[0] ? bitv : ~bitv;
            cfg_wr_en = combo[1] ? bitv : ~bitv;
            for (int k = 0; k < 2; k++) begin
               for (int c = 0; c < 4; c++) begin
                  for (int w = 0; w < 2; w++) begin
                     step(1'b1, (k == 0) ? lo : hi, w[0], 2'(c), 4'b1011);
                  end
               end
            end
         end
      end

      // R7..R10: main range edges with exception regions off, then on.
      for (int en = 0; en < 2; en++) begin
         cfg_hole_en = en[0]; cfg_smm_en = en[0]; cfg_gfx_en = en[0];
         for (int i = 0; i < 17; i++) begin
            step(1'b1, maddr[i], 1'b0, 2'd0, 4'b0110);
            step(1'b1, maddr[i], 1'b1, 2'd3, 4'b1001);
         end
      end

      // R7: top boundary pulled down to 1 MB, so the whole main range goes to the link.
      cfg_tolud = 32'h0010_0000;
      cfg_hole_en = 1'b0; cfg_smm_en = 1'b0; cfg_gfx_en = 1'b0;
      step(1'b1, 32'h0010_0000, 1'b0, 2'd1, 4'hF);
      step(1'b1, 32'h000F_FFFF, 1'b0, 2'd2, 4'hF);
      step(1'b0, 32'h0010_0000, 1'b0, 2'd0, 4'hF);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule